// File: doc/BRIEF.md
# Coarse Quarter/Eighth-Rate Digital Mixer

This block shifts a stream of signed I/Q samples in frequency by a quarter or an eighth of the sample rate, in either direction. It sits directly in front of a dual DAC. It has two mixing modes. In complex mode the I/Q pair is one complex sample that is rotated by a stepping phase, so the whole spectrum moves one way. In real mode each channel is multiplied by its own cosine carrier, so the signal and its mirror image both move.

The quarter-rate carrier takes only the values 0 and ±1. It is applied by swapping and negating samples. The eighth-rate carrier also needs ±√2/2, which is a fixed-point constant. Every result is rounded and then clamped to the sample width.

The control inputs are registered, and after reset they hold the bypass setting. Every mode, including bypass, goes through the same two-stage pipeline. A mode change therefore never moves the output samples in time relative to each other.

Top module: `coarse_mixer`

## Requirements
- R1: While reset is active and after it is released, valid_o, i_o and q_o are 0. The registered configuration resets to bypass, so a sample presented in the first cycle after release comes out unchanged, whatever the control pins carry.
- R2: valid_o is valid_i delayed by exactly two clock cycles, in every mode. The data on i_o/q_o belongs to that delayed sample.
- R3: With bypass_i=1 in effect, i_o and q_o equal the input I and Q samples unchanged.
- R4: Complex quarter-rate mode (bypass_i=0, real_i=0, eighth_i=0, neg_i=0) outputs I·cos(n·90°) − Q·sin(n·90°) and I·sin(n·90°) + Q·cos(n·90°). Here n counts the valid samples since the phase was last cleared, starting at 0.
- R5: Complex eighth-rate mode (eighth_i=1) uses the same rotation with n·45°. √2/2 is represented as 11585/16384. The exact sum is rounded as floor(x/16384 + 1/2).
- R6: neg_i=1 in complex mode reverses the rotation: the sine terms change sign.
- R7: In real mode (real_i=1) the outputs are I·cos(n·θ) and Q·cos(n·θ), each channel on its own. neg_i has no effect in real mode.
- R8: The phase advances by one step only on a cycle with valid_i=1. Idle cycles leave it unchanged.
- R9: Any change of the control fields clears the phase to 0, and the phase is held at 0 while bypass is in effect.
- R10: Any result outside the 14-bit range is clamped to 8191 or −8192. Negating −8192 therefore gives 8191.
- R11: Control inputs take effect one cycle after they are presented. A sample presented in the same cycle as a control change is processed with the previous settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| i_i | input | 14 | In-phase sample, signed |
| q_i | input | 14 | Quadrature sample, signed |
| bypass_i | input | 1 | 1 = pass samples through unchanged |
| eighth_i | input | 1 | 0 = quarter-rate shift, 1 = eighth-rate shift |
| neg_i | input | 1 | 1 = negative shift direction |
| real_i | input | 1 | 1 = independent real mix per channel, 0 = complex rotation |
| valid_o | output | 1 | Output sample strobe |
| i_o | output | 14 | Mixed in-phase sample, signed |
| q_o | output | 14 | Mixed quadrature sample, signed |

## Verification
The bench walks all sixteen settings of the four control bits. For each setting it drives the full 8×8 cross of I/Q values, which includes both rails, ±1 and 0. Idle cycles are placed in the stream at a fixed spacing.

The cross product catches a swapped or mis-signed sine term, because I and Q take different values. The rail values expose a missing clamp or a wrong rounding step on the √2/2 products. The idle cycles show whether the phase steps on the strobe or on the clock. Moving from one setting to the next, and changing the controls in the middle of a stream, shows whether the phase clears, and whether the sample presented in the changing cycle still uses the previous settings.

// File: rtl/cmix_pkg.sv
package cmix_pkg;

  typedef enum logic [2:0] {
    LO_ZERO,
    LO_P1,
    LO_N1,
    LO_PC,
    LO_NC
  } lo_e;

  typedef struct packed {
    logic bypass;
    logic eighth;
    logic neg;
    logic real_mix;
  } cfg_t;

  localparam cfg_t CFG_RST = '{bypass: 1'b1, eighth: 1'b0, neg: 1'b0, real_mix: 1'b0};

  function automatic lo_e lo_neg(lo_e c);
    case (c)
      LO_P1:   return LO_N1;
      LO_N1:   return LO_P1;
      LO_PC:   return LO_NC;
      LO_NC:   return LO_PC;
      default: return LO_ZERO;
    endcase
  endfunction

  // cos(k*45 deg)
  function automatic lo_e lo_cos(logic [2:0] k);
    case (k)
      3'd0:    return LO_P1;
      3'd1:    return LO_PC;
      3'd2:    return LO_ZERO;
      3'd3:    return LO_NC;
      3'd4:    return LO_N1;
      3'd5:    return LO_NC;
      3'd6:    return LO_ZERO;
      default: return LO_PC;
    endcase
  endfunction

  // sin(x) = cos(x - 90 deg)
  function automatic lo_e lo_sin(logic [2:0] k);
    return lo_cos(k - 3'd2);
  endfunction

endpackage

// File: rtl/cmix_phase.sv
module cmix_phase
  import cmix_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  cfg_t       cfg_d_i,
  input  logic       valid_i,
  output cfg_t       cfg_o,
  output logic [2:0] phase_o
);

  cfg_t       cfg_q;
  logic [2:0] phase_q;
  logic [2:0] step;

  // phase is in 45 deg units; quarter rate steps by two
  assign step = cfg_q.eighth ? 3'd1 : 3'd2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= CFG_RST;
      phase_q <= '0;
    end else begin
      cfg_q <= cfg_d_i;
      if (cfg_d_i != cfg_q || cfg_d_i.bypass) begin
        phase_q <= '0;
      end else if (valid_i) begin
        phase_q <= phase_q + step;
      end
    end
  end

  assign cfg_o   = cfg_q;
  assign phase_o = phase_q;

endmodule

// File: rtl/cmix_lo.sv
module cmix_lo
  import cmix_pkg::*;
(
  input  cfg_t       cfg_i,
  input  logic [2:0] phase_i,
  output lo_e        lo_o [4]
);

  // lo_o[0]: I->I, [1]: Q->I, [2]: I->Q, [3]: Q->Q
  lo_e c_lo, s_lo, s_eff;

  always_comb begin
    c_lo  = lo_cos(phase_i);
    s_lo  = lo_sin(phase_i);
    s_eff = cfg_i.neg ? lo_neg(s_lo) : s_lo;
    lo_o  = '{default: LO_ZERO};
    if (cfg_i.bypass) begin
      lo_o[0] = LO_P1;
      lo_o[3] = LO_P1;
    end else if (cfg_i.real_mix) begin
      lo_o[0] = c_lo;
      lo_o[3] = c_lo;
    end else begin
      lo_o[0] = c_lo;
      lo_o[1] = lo_neg(s_eff);
      lo_o[2] = s_eff;
      lo_o[3] = c_lo;
    end
  end

endmodule

// File: rtl/cmix_term.sv
module cmix_term
  import cmix_pkg::*;
#(
  parameter int DW   = 14,
  parameter int FRAC = 14
) (
  input  logic signed [DW-1:0]   x_i,
  input  lo_e                    lo_i,
  output logic signed [DW+FRAC:0] p_o
);

  localparam int PW = DW + FRAC + 1;
  localparam int KC = $rtoi(0.7071067811865476 * (2.0 ** FRAC) + 0.5);
  localparam logic signed [PW-1:0] KCV = PW'(KC);

  logic signed [PW-1:0] xe, unit, scl;

  assign xe   = {{(PW-DW){x_i[DW-1]}}, x_i};
  assign unit = xe <<< FRAC;
  assign scl  = xe * KCV;

  always_comb begin
    case (lo_i)
      LO_P1:   p_o = unit;
      LO_N1:   p_o = -unit;
      LO_PC:   p_o = scl;
      LO_NC:   p_o = -scl;
      default: p_o = '0;
    endcase
  end

endmodule

// File: rtl/cmix_sum.sv
module cmix_sum #(
  parameter int DW   = 14,
  parameter int FRAC = 14
) (
  input  logic signed [DW+FRAC:0] a_i,
  input  logic signed [DW+FRAC:0] b_i,
  output logic signed [DW-1:0]    y_o
);

  localparam int PW = DW + FRAC + 1;
  localparam int SW = PW + 1;
  localparam logic signed [SW-1:0] HALF = SW'(2 ** (FRAC - 1));
  localparam logic signed [SW-1:0] MAXV = SW'(2 ** (DW - 1) - 1);
  localparam logic signed [SW-1:0] MINV = ~MAXV;

  logic signed [SW-1:0] s, r;

  assign s = $signed({a_i[PW-1], a_i}) + $signed({b_i[PW-1], b_i});
  assign r = (s + HALF) >>> FRAC;

  always_comb begin
    if (r > MAXV)      y_o = {1'b0, {(DW-1){1'b1}}};
    else if (r < MINV) y_o = {1'b1, {(DW-1){1'b0}}};
    else               y_o = r[DW-1:0];
  end

endmodule

// File: rtl/coarse_mixer.sv
module coarse_mixer
  import cmix_pkg::*;
#(
  parameter int DW   = 14,
  parameter int FRAC = 14
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic signed [DW-1:0] i_i,
  input  logic signed [DW-1:0] q_i,
  input  logic                 bypass_i,
  input  logic                 eighth_i,
  input  logic                 neg_i,
  input  logic                 real_i,
  output logic                 valid_o,
  output logic signed [DW-1:0] i_o,
  output logic signed [DW-1:0] q_o
);

  localparam int PW = DW + FRAC + 1;
  localparam int NT = 4;

  cfg_t       cfg_d, cfg_q;
  logic [2:0] phase_q;
  lo_e        lo_c [NT];

  assign cfg_d = '{bypass: bypass_i, eighth: eighth_i, neg: neg_i, real_mix: real_i};

  cmix_phase u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cfg_d_i (cfg_d),
    .valid_i (valid_i),
    .cfg_o   (cfg_q),
    .phase_o (phase_q)
  );

  cmix_lo u_lo (
    .cfg_i   (cfg_q),
    .phase_i (phase_q),
    .lo_o    (lo_c)
  );

  // stage 1: sample and carrier codes
  logic                 s1_valid;
  logic signed [DW-1:0] s1_i, s1_q;
  lo_e                  s1_lo [NT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_i     <= '0;
      s1_q     <= '0;
      s1_lo    <= '{default: LO_ZERO};
    end else begin
      s1_valid <= valid_i;
      s1_i     <= i_i;
      s1_q     <= q_i;
      s1_lo    <= lo_c;
    end
  end

  // stage 2: products, sum, round, clamp
  logic signed [PW-1:0] term [NT];
  logic signed [DW-1:0] mix  [2];

  for (genvar g = 0; g < NT; g++) begin : g_term
    cmix_term #(.DW(DW), .FRAC(FRAC)) u_term (
      .x_i  ((g % 2 == 0) ? s1_i : s1_q),
      .lo_i (s1_lo[g]),
      .p_o  (term[g])
    );
  end

  for (genvar g = 0; g < 2; g++) begin : g_sum
    cmix_sum #(.DW(DW), .FRAC(FRAC)) u_sum (
      .a_i (term[2*g]),
      .b_i (term[2*g+1]),
      .y_o (mix[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      i_o     <= '0;
      q_o     <= '0;
    end else begin
      valid_o <= s1_valid;
      i_o     <= mix[0];
      q_o     <= mix[1];
    end
  end

endmodule

// File: rtl/cmix_chk.sv
module cmix_chk
  import cmix_pkg::*;
#(
  parameter int DW = 14
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic signed [DW-1:0] i_i,
  input logic signed [DW-1:0] q_i,
  input logic                 valid_o,
  input logic signed [DW-1:0] i_o,
  input logic signed [DW-1:0] q_o,
  input cfg_t                 cfg_d,
  input cfg_t                 cfg_q,
  input logic [2:0]           phase_q
);

  // R2
  lat_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ##2 valid_o);

  // R2
  lat_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> ##2 !valid_o);

  // R3
  byp_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cfg_q.bypass) |-> ##2 (i_o == $past(i_i, 2) && q_o == $past(q_i, 2)));

  // R9
  phase_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_d != cfg_q) |=> (phase_q == 3'd0));

  // R8
  phase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && cfg_d == cfg_q) |=> $stable(phase_q));

  // R7
  real_null_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !cfg_q.bypass && cfg_q.real_mix && !cfg_q.eighth && phase_q[1])
      |-> ##2 (i_o == '0 && q_o == '0));

endmodule

bind coarse_mixer cmix_chk #(.DW(DW)) u_cmix_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .i_i     (i_i),
  .q_i     (q_i),
  .valid_o (valid_o),
  .i_o     (i_o),
  .q_o     (q_o),
  .cfg_d   (cfg_d),
  .cfg_q   (cfg_q),
  .phase_q (phase_q)
);

// File: tb/tb_coarse_mixer.sv
`timescale 1ns/1ps
module tb_coarse_mixer;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              valid_i = 1'b0;
  logic signed [13:0] i_i = '0, q_i = '0;
  logic              bypass_i = 1'b1, eighth_i = 1'b0, neg_i = 1'b0, real_i = 1'b0;
  logic              valid_o;
  logic signed [13:0] i_o, q_o;

  always #5 clk = ~clk;

  coarse_mixer dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .i_i(i_i), .q_i(q_i),
    .bypass_i(bypass_i), .eighth_i(eighth_i), .neg_i(neg_i), .real_i(real_i),
    .valid_o(valid_o), .i_o(i_o), .q_o(q_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // model state: ctl = {bypass, eighth, neg, real}
  logic [3:0] m_cfg = 4'b1000;
  int         m_ph  = 0;
  bit d1_v = 0, d2_v = 0;
  int d1_i = 0, d1_q = 0, d2_i = 0, d2_q = 0;
  string d1_t = "R2", d2_t = "R2";

  function automatic longint cosv(int k);
    case (((k % 8) + 8) % 8)
      0: return 16384;
      1: return 11585;
      2: return 0;
      3: return -11585;
      4: return -16384;
      5: return -11585;
      6: return 0;
      default: return 11585;
    endcase
  endfunction

  function automatic int rnd_sat(longint x);
    longint r;
    r = (x + 8192) >>> 14;
    if (r > 8191) return 8191;
    if (r < -8192) return -8192;
    return int'(r);
  endfunction

  task automatic model(input int iv, input int qv, output int ei, output int eq);
    longint c, s;
    if (m_cfg[3]) begin
      ei = iv; eq = qv;
    end else begin
      c = cosv(m_ph);
      s = cosv(m_ph - 2);
      if (m_cfg[1]) s = -s;
      if (m_cfg[0]) begin
        ei = rnd_sat(longint'(iv) * c);
        eq = rnd_sat(longint'(qv) * c);
      end else begin
        ei = rnd_sat(longint'(iv) * c - longint'(qv) * s);
        eq = rnd_sat(longint'(iv) * s + longint'(qv) * c);
      end
    end
  endtask

  task automatic step(input bit v, input int iv, input int qv, input logic [3:0] ctl, input string tag);
    int ei, eq;
    @(negedge clk);
    n_chk++;
    if (valid_o !== d2_v) begin
      n_fail++;
      $display("FAIL R2 valid_o act=%0b exp=%0b", valid_o, d2_v);
    end else if (d2_v && (int'(i_o) != d2_i || int'(q_o) != d2_q)) begin
      n_fail++;
      $display("FAIL %s act=(%0d,%0d) exp=(%0d,%0d)", d2_t, i_o, q_o, d2_i, d2_q);
    end
    model(iv, qv, ei, eq);
    d2_v = d1_v; d2_i = d1_i; d2_q = d1_q; d2_t = d1_t;
    d1_v = v;    d1_i = ei;   d1_q = eq;   d1_t = tag;
    valid_i = v; i_i = 14'(iv); q_i = 14'(qv);
    {bypass_i, eighth_i, neg_i, real_i} = ctl;
    // control registered: applies next cycle, phase cleared on change (R9, R11)
    if (ctl != m_cfg || ctl[3]) m_ph = 0;
    else if (v) m_ph = (m_ph + (m_cfg[2] ? 1 : 2)) % 8;
    m_cfg = ctl;
  endtask

  function automatic string tag_of(logic [3:0] ctl, int iv, int qv);
    if (iv == -8192 || qv == -8192) return "R10";
    if (ctl[3]) return "R3";
    if (ctl[0]) return "R7";
    if (ctl[1]) return "R6";
    if (ctl[2]) return "R5";
    return "R4";
  endfunction

  int vals[8] = '{-8192, -8191, -4097, -1, 0, 1, 3000, 8191};

  initial begin
    // R1: reset state
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      n_chk++;
      if (valid_o !== 1'b0 || i_o !== '0 || q_o !== '0) begin
        n_fail++;
        $display("FAIL R1 reset act=(%0b,%0d,%0d) exp=(0,0,0)", valid_o, i_o, q_o);
      end
    end
    rst_ni = 1'b1;
    // R1/R11: first sample after reset passes unchanged despite non-bypass pins
    step(1, 1234, -77, 4'b0100, "R1");
    step(1, 2000, 500, 4'b0100, "R11");
    step(1, 2000, 500, 4'b0100, "R5");
    // R11: sample in the cycle of a change uses old settings
    step(1, -3000, 4000, 4'b0000, "R11");
    step(1, -3000, 4000, 4'b0000, "R9");
    step(1, -3000, 4000, 4'b0000, "R4");
    // sweep all settings over the full value cross with idle gaps (R8)
    for (int c = 0; c < 16; c++) begin
      for (int a = 0; a < 8; a++) begin
        for (int b = 0; b < 8; b++) begin
          if ((a * 8 + b) % 7 == 3) step(0, 0, 0, 4'(c), "R8");
          step(1, vals[a], vals[b], 4'(c), tag_of(4'(c), vals[a], vals[b]));
        end
      end
    end
    // R9: mid-stream switches between quarter and eighth rate
    for (int k = 0; k < 24; k++) begin
      step(1, 5000 - k * 300, 700 + k * 200, (k / 5) % 2 ? 4'b0100 : 4'b0000, "R9");
    end
    // R10: rails in eighth-rate complex mode
    for (int k = 0; k < 16; k++) begin
      step(1, (k % 2) ? 8191 : -8192, (k % 3) ? -8192 : 8191, 4'b0100, "R10");
    end
    step(0, 0, 0, 4'b1000, "R2");
    step(0, 0, 0, 4'b1000, "R2");
    step(0, 0, 0, 4'b1000, "R2");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule